// File: doc/BRIEF.md
# Gray-Coded Event Timer with Match Interrupt

This block is a free-running 42-bit event counter that software reads over a simple synchronous register bus. The count is always shown in Gray code, so a reader that samples the two halves at slightly different moments sees at most one changed bit between neighbouring values. A Gray-coded match value can be programmed. When the Gray-coded count equals the committed match value, a sticky interrupt flag is set. An enable bit routes that flag to the `irq` output.

A match update is written in two steps: the low word first, then the high word. The high-word write starts a commit that takes a fixed number of cycles. This stands in for a clock-domain crossing. While the commit is in progress a busy bit reads 1, and the comparator keeps using the previous match value. After reset the match registers hold all ones. This parks the comparator far from the count, so no interrupt fires before software programs a real target.

Register map (word addresses on `bus_addr`):
- 0: count, Gray bits 31:0
- 1: count, Gray bits 41:32
- 2: match low
- 3: match high
- 4: control

Top module: `gray_event_timer`

## Requirements
- R1: After reset the binary count is zero and increases by exactly one on every clock, wrapping from 2^42-1 back to 0.
- R2: A read of address 0 returns Gray count bits 31:0. A read of address 1 returns Gray count bits 41:32 in bits 9:0, and bits 31:10 read as zero.
- R3: The count presented on the bus is binary XOR (binary shifted right by one), so successive count values differ in exactly one bit.
- R4: Address 2 stages the low 32 bits of the Gray match value and address 3 stages bits 41:32 (from write data bits 9:0). Reads of addresses 2 and 3 return the staged values.
- R5: Control bit 2 (busy) reads 1 during the 4 cycles that follow a write to address 3, and reads 0 otherwise.
- R6: The comparator keeps the previous match value until the commit 4 cycles after the high write. A target the count passes during the busy window is missed. A target equal to the count in the first cycle after the commit is caught.
- R7: Control bit 1 (flag) becomes 1 on the clock edge that ends a cycle in which the Gray count equals the committed match value. It stays 1 until a control write with bit 1 set clears it. Writing 0 to bit 1 has no effect.
- R8: Control bit 0 (enable) is read/write and `irq` equals flag AND enable. Clearing enable masks `irq` and leaves the flag intact.
- R9: A control write with bit 1 set, made in the same cycle as a match hit, leaves the flag set.
- R10: Reset state: count 0, flag, enable, busy and `irq` all 0, and both match registers all ones. No flag is raised while the match is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, 0 when not reading |
| irq | output | 1 | Interrupt: flag AND enable |

## Verification
The bound checker watches, on every cycle:
- that the count steps by one;
- that successive Gray values differ in a single bit;
- that busy rises only after a high-word write;
- that the committed match changes only on a commit strobe;
- that the flag rises only after a hit and falls only on a clear;
- that a clear arriving together with a hit leaves the flag set.

Only the bench scenarios can show the rest:
- the exact cycle in which the flag appears relative to the programmed target;
- the miss and catch boundaries around the commit latency;
- the register read-back values;
- masking of `irq` while the flag is kept.

// File: rtl/gevt_pkg.sv
package gevt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_MAT_LO = 3'd2,
    REG_MAT_HI = 3'd3,
    REG_CTRL   = 3'd4
  } gevt_reg_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;
  localparam int CTRL_BUSY_BIT = 2;
endpackage

// File: rtl/gevt_counter.sv
module gevt_counter #(
  parameter int CNT_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_bin,
  output logic [CNT_W-1:0] cnt_gray
);
  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_bin <= '0;
    else        cnt_bin <= cnt_bin + 1'b1;
  end

  assign cnt_gray = bin_to_gray(cnt_bin);
endmodule

// File: rtl/gevt_match_stage.sv
module gevt_match_stage #(
  parameter int CNT_W = 42,
  parameter int LO_W  = 32,
  parameter int LAT   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lo_wr,
  input  logic                  hi_wr,
  input  logic [LO_W-1:0]       wdata,
  output logic [LO_W-1:0]       stage_lo,
  output logic [CNT_W-LO_W-1:0] stage_hi,
  output logic [CNT_W-1:0]      match_q,
  output logic                  busy,
  output logic                  commit_ev
);
  localparam int HI_W  = CNT_W - LO_W;
  localparam int LAT_W = $clog2(LAT + 1);

  logic [LAT_W-1:0] pend;

  assign busy      = (pend != '0);
  assign commit_ev = (pend == LAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo <= '1;
      stage_hi <= '1;
      match_q  <= '1;
      pend     <= '0;
    end else begin
      if (lo_wr) stage_lo <= wdata;
      if (hi_wr) stage_hi <= wdata[HI_W-1:0];
      if (hi_wr)     pend <= LAT_W'(LAT);
      else if (busy) pend <= pend - 1'b1;
      if (commit_ev) match_q <= {stage_hi, stage_lo};
    end
  end
endmodule

// File: rtl/gevt_irq_ctrl.sv
module gevt_irq_ctrl #(
  parameter int CNT_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_gray,
  input  logic [CNT_W-1:0] match_q,
  input  logic             ctrl_wr,
  input  logic             wr_en_bit,
  input  logic             wr_clr_bit,
  output logic             hit_ev,
  output logic             clr_ev,
  output logic             en_q,
  output logic             flag_q,
  output logic             irq
);
  function automatic logic next_flag(input logic cur, input logic hit, input logic clr);
    return hit | (cur & ~clr);
  endfunction

  assign hit_ev = (cnt_gray == match_q);
  assign clr_ev = ctrl_wr & wr_clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= next_flag(flag_q, hit_ev, clr_ev);
      if (ctrl_wr) en_q <= wr_en_bit;
    end
  end

  assign irq = flag_q & en_q;
endmodule

// File: rtl/gray_event_timer.sv
module gray_event_timer #(
  parameter int CNT_W      = 42,
  parameter int DATA_W     = 32,
  parameter int COMMIT_LAT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [gevt_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq
);
  import gevt_pkg::*;

  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0]  cnt_bin, cnt_gray, match_q;
  logic [DATA_W-1:0] stage_lo;
  logic [HI_W-1:0]   stage_hi;
  logic wr_go, mat_lo_wr, mat_hi_wr, ctrl_wr;
  logic busy, commit_ev, hit_ev, clr_ev, en_q, flag_q;

  assign wr_go     = bus_sel & bus_wr;
  assign mat_lo_wr = wr_go && (bus_addr == REG_MAT_LO);
  assign mat_hi_wr = wr_go && (bus_addr == REG_MAT_HI);
  assign ctrl_wr   = wr_go && (bus_addr == REG_CTRL);

  gevt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_bin  (cnt_bin),
    .cnt_gray (cnt_gray)
  );

  gevt_match_stage #(.CNT_W(CNT_W), .LO_W(DATA_W), .LAT(COMMIT_LAT)) u_mat (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_wr     (mat_lo_wr),
    .hi_wr     (mat_hi_wr),
    .wdata     (bus_wdata),
    .stage_lo  (stage_lo),
    .stage_hi  (stage_hi),
    .match_q   (match_q),
    .busy      (busy),
    .commit_ev (commit_ev)
  );

  gevt_irq_ctrl #(.CNT_W(CNT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_gray   (cnt_gray),
    .match_q    (match_q),
    .ctrl_wr    (ctrl_wr),
    .wr_en_bit  (bus_wdata[CTRL_EN_BIT]),
    .wr_clr_bit (bus_wdata[CTRL_FLAG_BIT]),
    .hit_ev     (hit_ev),
    .clr_ev     (clr_ev),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .irq        (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (gevt_reg_e'(bus_addr))
        REG_CNT_LO: bus_rdata = cnt_gray[DATA_W-1:0];
        REG_CNT_HI: bus_rdata[HI_W-1:0] = cnt_gray[CNT_W-1:DATA_W];
        REG_MAT_LO: bus_rdata = stage_lo;
        REG_MAT_HI: bus_rdata[HI_W-1:0] = stage_hi;
        REG_CTRL: begin
          bus_rdata[CTRL_EN_BIT]   = en_q;
          bus_rdata[CTRL_FLAG_BIT] = flag_q;
          bus_rdata[CTRL_BUSY_BIT] = busy;
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gevt_sva.sv
module gevt_sva #(
  parameter int CNT_W = 42
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_bin,
  input logic [CNT_W-1:0] cnt_gray,
  input logic [CNT_W-1:0] match_q,
  input logic             hi_wr,
  input logic             busy,
  input logic             commit_ev,
  input logic             hit_ev,
  input logic             clr_ev,
  input logic             en_q,
  input logic             flag_q,
  input logic             irq
);
  logic pv;
  always_ff @(posedge clk) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> cnt_bin == CNT_W'($past(cnt_bin) + 1'b1));

  a_r3_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> $countones(cnt_gray ^ $past(cnt_gray)) == 1);

  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> busy);

  a_r5_busy_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $rose(busy)) |-> $past(hi_wr));

  a_r6_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && !$stable(match_q)) |-> $past(commit_ev));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> flag_q);

  a_r7_flag_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $rose(flag_q)) |-> $past(hit_ev));

  a_r7_flag_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $fell(flag_q)) |-> $past(clr_ev));

  a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq);

  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && hit_ev) |=> flag_q);
endmodule

bind gray_event_timer gevt_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_bin   (cnt_bin),
  .cnt_gray  (cnt_gray),
  .match_q   (match_q),
  .hi_wr     (mat_hi_wr),
  .busy      (busy),
  .commit_ev (commit_ev),
  .hit_ev    (hit_ev),
  .clr_ev    (clr_ev),
  .en_q      (en_q),
  .flag_q    (flag_q),
  .irq       (irq)
);

// File: tb/gray_event_timer_tb.sv
`timescale 1ns/100ps
module gray_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] tb_ticks;

  always #2.5 clk = ~clk;

  gray_event_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Bench's own model of elapsed clocks since reset.
  always @(posedge clk) begin
    if (!rst_n) tb_ticks <= 64'd0;
    else        tb_ticks <= tb_ticks + 64'd1;
  end

  // Stimulus table: [17] expected irq at flag rise, [16] enable, [15:0] target distance.
  localparam logic [17:0] VEC [0:5] = '{
    {1'b1, 1'b1, 16'd6},
    {1'b0, 1'b0, 16'd9},
    {1'b1, 1'b1, 16'd17},
    {1'b0, 1'b0, 16'd33},
    {1'b1, 1'b1, 16'd64},
    {1'b1, 1'b1, 16'd150}
  };

  function automatic logic [63:0] ref_gray(input logic [63:0] b);
    logic [63:0] g;
    for (int i = 0; i < 64; i++) g[i] = b[i] ^ ((i < 63) ? b[i+1] : 1'b0);
    return g;
  endfunction

  function automatic logic [63:0] ref_bin(input logic [63:0] g);
    logic [63:0] b;
    b[63] = g[63];
    for (int i = 62; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; samples combinational read data 1 ns later.
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic program_match(input logic [63:0] target);
    logic [63:0] g;
    g = ref_gray(target);
    wr(3'd2, g[31:0]);
    wr(3'd3, {22'd0, g[41:32]});
  endtask

  // Polls control until the flag is seen; returns tb_ticks at that sample.
  task automatic wait_flag(output logic [63:0] at_tick, output logic seen_irq);
    logic [31:0] d;
    at_tick = '1; seen_irq = 1'b0;
    for (int k = 0; k < 400; k++) begin
      rd(3'd4, d);
      if (d[1]) begin
        at_tick = tb_ticks; seen_irq = irq;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    logic [63:0] s, t, tgt;
    logic        si;

    // R10: reset state, read during reset
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R10 count lo in reset", d, 0);
    rd(3'd1, d); check("R10 count hi in reset", d, 0);
    rd(3'd2, d); check("R10 parked match lo", d, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R10 parked match hi", d, 32'h3FF);
    rd(3'd4, d); check("R10 ctrl in reset", d, 0);
    check("R10 irq in reset", irq, 0);
    rst_n = 1'b1;

    // R1 / R2 / R3: count read-back over consecutive cycles
    repeat (5) @(negedge clk);
    rd(3'd0, prev);
    check("R2 count lo gray", prev, ref_gray(tb_ticks) & 64'hFFFF_FFFF);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rd(3'd0, d);
      check("R1 count binary equals elapsed clocks", ref_bin({32'd0, d}), tb_ticks);
      check("R3 single-bit Gray step", $countones(d ^ prev), 1);
      prev = d;
    end
    @(negedge clk);
    rd(3'd1, d); check("R2 count hi with zero upper bits", d, {22'd0, ref_gray(tb_ticks)[41:32]});

    // R10: no flag while parked
    repeat (50) @(negedge clk);
    rd(3'd4, d); check("R10 no flag while parked", d[1], 0);

    // R4 / R5: staging read-back and busy window
    s = tb_ticks;
    tgt = s + 64'd300;
    program_match(tgt);
    for (int k = 0; k < 5; k++) begin
      rd(3'd4, d);
      check($sformatf("R5 busy sample %0d", k), d[2], (k < 4) ? 1 : 0);
      @(negedge clk);
    end
    rd(3'd2, d); check("R4 match lo readback", d, ref_gray(tgt) & 64'hFFFF_FFFF);
    rd(3'd3, d); check("R4 match hi readback", d, {22'd0, ref_gray(tgt)[41:32]});
    wait_flag(t, si);
    check("R7 flag rises one clock after equality", t, tgt + 64'd1);
    wr(3'd4, 32'h2);
    rd(3'd4, d); check("R7 W1C clears flag", d[1], 0);

    // R6: target passed during the busy window is missed
    s = tb_ticks;
    program_match(s + 64'd5);
    repeat (20) @(negedge clk);
    rd(3'd4, d); check("R6 target during busy missed", d[1], 0);

    // R6 / R7 / R8: table of targets and enables
    foreach (VEC[i]) begin
      wr(3'd4, {31'd0, VEC[i][16]});
      s = tb_ticks;
      tgt = s + 64'(VEC[i][15:0]);
      program_match(tgt);
      wait_flag(t, si);
      check($sformatf("R6 R7 vec%0d flag tick", i), t, tgt + 64'd1);
      check($sformatf("R8 vec%0d irq gated by enable", i), si, VEC[i][17]);
      @(negedge clk);
      wr(3'd4, {30'd0, 1'b1, VEC[i][16]});
      rd(3'd4, d); check($sformatf("R7 vec%0d flag cleared", i), d[1], 0);
      check($sformatf("R8 vec%0d irq low after clear", i), irq, 0);
    end

    // R8 / R7: masking keeps the flag, writing 0 to the flag does nothing
    wr(3'd4, 32'h0);
    s = tb_ticks;
    program_match(s + 64'd12);
    wait_flag(t, si);
    check("R8 masked irq low", si, 0);
    @(negedge clk);
    wr(3'd4, 32'h1);
    rd(3'd4, d); check("R7 writing 0 to flag keeps it", d[1], 1);
    check("R8 irq after enabling", irq, 1);
    wr(3'd4, 32'h0);
    rd(3'd4, d); check("R8 flag kept while masked", d[1], 1);
    check("R8 irq masked", irq, 0);
    wr(3'd4, 32'h2);
    rd(3'd4, d); check("R7 cleared after mask test", d[1], 0);

    // R9: clear in the same cycle as a hit
    s = tb_ticks;
    tgt = s + 64'd20;
    program_match(tgt);
    while (tb_ticks != tgt) @(negedge clk);
    wr(3'd4, 32'h3);
    rd(3'd4, d); check("R9 clear coinciding with hit keeps flag", d[1], 1);
    wr(3'd4, 32'h3);
    rd(3'd4, d); check("R9 later clear removes flag", d[1], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule